// File: doc/BRIEF.md
# LSB-First SPI Command Slave

This block is the serial command front end of a message record and playback device. An external host selects it with an active-low select line and clocks in frames of two to seven bytes. Each frame starts with an opcode, and the opcode fixes how many bytes follow. At the same time the block shifts out a status echo. Both directions move the least significant bit first. The serial pins are brought into the system clock domain through synchronizers, so SCLK must run well below the system clock.

The block decodes each completed frame against its current operating mode. An accepted command produces a one-cycle strobe and updates the configuration word or the row address pair. A command that the mode forbids only raises the command-error flag. A single busy/done pair of inputs stands in for the memory and audio engines. One input says that an operation has latched its addresses and begun, and the other says that it has finished.

Opcodes: power-up 0x01, stop 0x02, reset 0x03, clear-interrupt 0x04, read-status 0x05, power-down 0x07, play 0x40, record 0x41, write-config 0x45, ranged play 0x80, ranged record 0x81. Any other opcode is unknown.

Top module: `spi_cmd_slave`

## Requirements
- R1: MOSI is sampled on rising SCLK edges while select is low, least significant bit of each byte first. The bus idles with select high, SCLK high and MOSI low.
- R2: MISO changes only after falling SCLK edges, least significant bit first. Bit 0 is valid before the first rising edge of the frame, and MISO is 0 while select is high.
- R3: The first two bytes shifted out in every frame hold the primary status word captured when select falls. Its bits are: [15:5] row address, [4] interrupt, [3] end-of-message, [2] powered-up, [1] memory full, [0] command error.
- R4: The third byte shifted out holds the secondary status captured when select falls. Its bits are: [3] recording, [2] playing, [0] ready, and all other bits are 0. This is how read-status (0x05, three bytes) returns it.
- R5: Frame length depends on the opcode: 3 bytes for 0x05 and 0x45, 7 bytes for 0x80 and 0x81, and 2 bytes for every other opcode. Bytes clocked after the length is reached are ignored. An unknown opcode is rejected as in R8.
- R6: Write-config (0x45) loads a 12-bit word from two bytes. Bits 7:0 come from frame byte 2, and bits 11:8 come from the low nibble of byte 3. The high nibble of byte 3 is ignored.
- R7: Ranged play (0x80) and ranged record (0x81) are 7-byte frames. Byte 2 is filler. Bytes 3 and 4 carry the 11-bit start row (low byte first), and bytes 5 and 6 carry the 11-bit end row (low byte first). Byte 7 is filler.
- R8: Acceptance depends on the mode, as listed below. A rejected or unknown command sets the command-error flag, gives no strobe and changes no output. An accepted command clears the command-error flag and gives exactly one strobe.
  - Power-down mode (after reset or reset/power-down commands) accepts power-up, reset, clear-interrupt, read-status and power-down.
  - Idle accepts every known command.
  - Play and record modes accept only stop, reset, clear-interrupt, read-status and power-down.
- R9: Ranged-play mode also accepts a further ranged play, which replaces the address pair. Ranged-record mode also accepts a further ranged record.
- R10: Ready drops to 0 when any play or record command is accepted. It stays 0 until the engine-begun input pulses.
- R11: Stop returns the block to idle and clears interrupt and end-of-message. An engine-done pulse in a play or record mode returns the block to idle and sets interrupt and end-of-message.
- R12: If select rises before the frame length is reached, the partial frame is discarded with no strobe and no state change.
- R13: Acceptance is judged on the mode before an engine-done pulse in the same cycle. The done effects apply first, and an accepted command's effects override them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from host, idles high |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial status out |
| row_addr | input | 11 | Current row reported in the status word |
| mem_full | input | 1 | Memory-full flag reported in the status word |
| eng_ack | input | 1 | Engine pulse: addresses latched, operation begun |
| eng_done | input | 1 | Engine pulse: operation finished |
| cmd_stb | output | 11 | One-hot strobe, bit order: power-up, stop, reset, clear-int, read-status, power-down, play, record, write-config, ranged play, ranged record |
| cfg_word | output | 12 | Configuration word |
| start_row | output | 11 | Start row of the ranged operation |
| end_row | output | 11 | End row of the ranged operation |

## Verification
A decoded command and an engine-done pulse can land in the same system-clock cycle. When they do, the mode, interrupt and error flags must follow the ordering in R13. The bench counts synchronizer and decode stages from the final rising SCLK edge and pulses eng_done exactly in the execute cycle. It does this three times: once with an accepted clear-interrupt, once with a rejected play and once with stop, all issued during a recording. Each outcome is judged through the status bytes of the following read-status frame.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

    localparam int ROW_W     = 11;
    localparam int CFG_W     = 12;
    localparam int MAX_BYTES = 7;
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int NCMD      = 11;
    localparam int SR0_W     = 16;
    localparam int SR1_W     = 8;
    localparam int TX_W      = SR0_W + SR1_W;

    localparam logic [7:0] OP_PU     = 8'h01;
    localparam logic [7:0] OP_STOP   = 8'h02;
    localparam logic [7:0] OP_RESET  = 8'h03;
    localparam logic [7:0] OP_CLRINT = 8'h04;
    localparam logic [7:0] OP_RDST   = 8'h05;
    localparam logic [7:0] OP_PD     = 8'h07;
    localparam logic [7:0] OP_PLAY   = 8'h40;
    localparam logic [7:0] OP_REC    = 8'h41;
    localparam logic [7:0] OP_CFG    = 8'h45;
    localparam logic [7:0] OP_RPLAY  = 8'h80;
    localparam logic [7:0] OP_RREC   = 8'h81;

    typedef enum logic [2:0] {
        M_PD, M_IDLE, M_PLAY, M_REC, M_RPLAY, M_RREC
    } mode_e;

    typedef enum logic [3:0] {
        C_PU     = 4'd0,
        C_STOP   = 4'd1,
        C_RESET  = 4'd2,
        C_CLRINT = 4'd3,
        C_RDST   = 4'd4,
        C_PD     = 4'd5,
        C_PLAY   = 4'd6,
        C_REC    = 4'd7,
        C_CFG    = 4'd8,
        C_RPLAY  = 4'd9,
        C_RREC   = 4'd10,
        C_BAD    = 4'd11
    } cmd_e;

    typedef logic [MAX_BYTES-1:0][7:0] frame_t;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             intr;
        logic             eom;
        logic             pwr;
        logic             full;
        logic             err;
    } sr0_t;

    typedef struct packed {
        logic [3:0] rsv_hi;
        logic       rec;
        logic       play;
        logic       rsv_lo;
        logic       rdy;
    } sr1_t;

    function automatic logic [CNT_W-1:0] frame_len(input logic [7:0] op);
        case (op)
            OP_RDST, OP_CFG:   return CNT_W'(3);
            OP_RPLAY, OP_RREC: return CNT_W'(MAX_BYTES);
            default:           return CNT_W'(2);
        endcase
    endfunction

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OP_PU:     return C_PU;
            OP_STOP:   return C_STOP;
            OP_RESET:  return C_RESET;
            OP_CLRINT: return C_CLRINT;
            OP_RDST:   return C_RDST;
            OP_PD:     return C_PD;
            OP_PLAY:   return C_PLAY;
            OP_REC:    return C_REC;
            OP_CFG:    return C_CFG;
            OP_RPLAY:  return C_RPLAY;
            OP_RREC:   return C_RREC;
            default:   return C_BAD;
        endcase
    endfunction

    function automatic logic mode_busy(input mode_e m);
        return (m == M_PLAY) || (m == M_REC) || (m == M_RPLAY) || (m == M_RREC);
    endfunction

    function automatic logic cmd_allowed(input mode_e m, input cmd_e c);
        logic base;
        base = (c == C_STOP) || (c == C_RESET) || (c == C_CLRINT) ||
               (c == C_RDST) || (c == C_PD);
        case (m)
            M_PD:    return (c == C_PU) || (c == C_RESET) || (c == C_CLRINT) ||
                            (c == C_RDST) || (c == C_PD);
            M_IDLE:  return c != C_BAD;
            M_PLAY,
            M_REC:   return base;
            M_RPLAY: return base || (c == C_RPLAY);
            M_RREC:  return base || (c == C_RREC);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic ss_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic ss_fall,
    output logic ss_act,
    output logic mosi_s
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE_V = 3'b011;

    logic [NPIN-1:0] stg [SYNC_STAGES+1];
    logic [NPIN-1:0] cur, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= SYNC_STAGES; i++) stg[i] <= IDLE_V;
        end else begin
            stg[0] <= {mosi, ss_n, sclk};
            for (int i = 1; i <= SYNC_STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign cur       = stg[SYNC_STAGES-1];
    assign prev      = stg[SYNC_STAGES];
    assign sclk_rise = cur[0] & ~prev[0];
    assign sclk_fall = ~cur[0] & prev[0];
    assign ss_fall   = ~cur[1] & prev[1];
    assign ss_act    = ~cur[1];
    assign mosi_s    = cur[2];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spicmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk_rise,
    input  logic   mosi_s,
    input  logic   ss_act,
    output logic   cmd_valid,
    output frame_t frame
);
    logic [7:0]       shreg, byte_nxt;
    logic [2:0]       bitcnt;
    logic [CNT_W-1:0] bytecnt, need, len_now;
    logic             done;

    always_comb begin
        byte_nxt = {mosi_s, shreg[7:1]};
        len_now  = (bytecnt == '0) ? frame_len(byte_nxt) : need;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bitcnt    <= '0;
            bytecnt   <= '0;
            need      <= CNT_W'(2);
            done      <= 1'b0;
            cmd_valid <= 1'b0;
            frame     <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (!ss_act) begin
                bitcnt  <= '0;
                bytecnt <= '0;
                done    <= 1'b0;
            end else if (sclk_rise && !done) begin
                shreg  <= byte_nxt;
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    frame[bytecnt] <= byte_nxt;
                    bytecnt        <= bytecnt + 1'b1;
                    if (bytecnt == '0) need <= len_now;
                    if ({1'b0, bytecnt} + 1'b1 == {1'b0, len_now}) begin
                        cmd_valid <= 1'b1;
                        done      <= 1'b1;
                    end
                end
            end
        end
    end

    p_abort_r12: assert property (@(posedge clk) disable iff (rst)
        !ss_act |=> !cmd_valid);

    p_len_reached_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (bytecnt == need));

    p_ignore_extra_r5: assert property (@(posedge clk) disable iff (rst)
        (done && ss_act) |=> ($stable(bytecnt) && !cmd_valid));

endmodule

// File: rtl/spi_tx.sv
module spi_tx
    import spicmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ss_fall,
    input  logic            ss_act,
    input  logic            sclk_rise,
    input  logic            sclk_fall,
    input  logic [TX_W-1:0] status,
    output logic            miso
);
    logic [TX_W-1:0] sh;
    logic            seen_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            seen_rise <= 1'b0;
        end else if (ss_fall) begin
            sh        <= status;
            seen_rise <= 1'b0;
        end else if (ss_act) begin
            if (sclk_rise) seen_rise <= 1'b1;
            if (sclk_fall && seen_rise) sh <= {1'b0, sh[TX_W-1:1]};
        end
    end

    assign miso = ss_act & sh[0];

    p_hold_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && !ss_fall) |=> $stable(sh));

    p_first_fall_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sclk_fall && !seen_rise && !ss_fall) |=> $stable(sh));

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spicmd_pkg::*;
#(
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  frame_t           frame,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             mem_full,
    input  logic             eng_ack,
    input  logic             eng_done,
    output logic [NCMD-1:0]  cmd_stb,
    output logic [CFG_W-1:0] cfg_word,
    output logic [ROW_W-1:0] start_row,
    output logic [ROW_W-1:0] end_row,
    output logic [TX_W-1:0]  status
);
    mode_e mode;
    cmd_e  cmd;
    logic  ok, err, intr, eom, rdy;
    sr0_t  sr0;
    sr1_t  sr1;
    logic  unused_bits;

    always_comb begin
        cmd = decode_op(frame[0]);
        ok  = cmd_allowed(mode, cmd);
    end

    assign unused_bits = ^{frame[6], frame[5][7:3], frame[3][7:3], frame[2][7:4]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= M_PD;
            err       <= 1'b0;
            intr      <= 1'b0;
            eom       <= 1'b0;
            rdy       <= 1'b1;
            cfg_word  <= CFG_DEFAULT;
            start_row <= '0;
            end_row   <= '0;
            cmd_stb   <= '0;
        end else begin
            cmd_stb <= '0;
            if (eng_ack) rdy <= 1'b1;
            if (eng_done && mode_busy(mode)) begin
                mode <= M_IDLE;
                intr <= 1'b1;
                eom  <= 1'b1;
            end
            if (cmd_valid) begin
                if (!ok) begin
                    err <= 1'b1;
                end else begin
                    err          <= 1'b0;
                    cmd_stb[cmd] <= 1'b1;
                    case (cmd)
                        C_PU: if (mode == M_PD) mode <= M_IDLE;
                        C_STOP: begin
                            mode <= M_IDLE;
                            intr <= 1'b0;
                            eom  <= 1'b0;
                            rdy  <= 1'b1;
                        end
                        C_RESET: begin
                            mode     <= M_PD;
                            intr     <= 1'b0;
                            eom      <= 1'b0;
                            rdy      <= 1'b1;
                            cfg_word <= CFG_DEFAULT;
                        end
                        C_CLRINT: begin
                            intr <= 1'b0;
                            eom  <= 1'b0;
                        end
                        C_PD: begin
                            mode <= M_PD;
                            rdy  <= 1'b1;
                        end
                        C_PLAY: begin
                            mode <= M_PLAY;
                            rdy  <= 1'b0;
                        end
                        C_REC: begin
                            mode <= M_REC;
                            rdy  <= 1'b0;
                        end
                        C_CFG: cfg_word <= {frame[2][3:0], frame[1]};
                        C_RPLAY, C_RREC: begin
                            start_row <= {frame[3][2:0], frame[2]};
                            end_row   <= {frame[5][2:0], frame[4]};
                            mode      <= (cmd == C_RPLAY) ? M_RPLAY : M_RREC;
                            rdy       <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        sr0.row    = row_addr;
        sr0.intr   = intr;
        sr0.eom    = eom;
        sr0.pwr    = (mode != M_PD);
        sr0.full   = mem_full;
        sr0.err    = err;
        sr1.rsv_hi = '0;
        sr1.rec    = (mode == M_REC) || (mode == M_RREC);
        sr1.play   = (mode == M_PLAY) || (mode == M_RPLAY);
        sr1.rsv_lo = 1'b0;
        sr1.rdy    = rdy;
        status     = {sr1, sr0};
    end

    p_stb_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb));

    p_reject_flags_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !ok) |=> (err && cmd_stb == '0));

    p_play_only_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[C_PLAY] |-> ($past(mode) == M_IDLE));

    p_rplay_gate_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[C_RPLAY] |-> ($past(mode) == M_IDLE || $past(mode) == M_RPLAY));

    p_rdy_low_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb[C_PLAY] || cmd_stb[C_REC] || cmd_stb[C_RPLAY] || cmd_stb[C_RREC]) |-> !rdy);

    p_stop_clears_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_stb[C_STOP] |-> (!intr && !eom && mode == M_IDLE));

    p_done_idle_r13: assert property (@(posedge clk) disable iff (rst)
        (eng_done && mode_busy(mode) && !cmd_valid) |=> (mode == M_IDLE && intr));

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
    import spicmd_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk,
    input  logic             ss_n,
    input  logic             mosi,
    output logic             miso,
    input  logic [ROW_W-1:0] row_addr,
    input  logic             mem_full,
    input  logic             eng_ack,
    input  logic             eng_done,
    output logic [NCMD-1:0]  cmd_stb,
    output logic [CFG_W-1:0] cfg_word,
    output logic [ROW_W-1:0] start_row,
    output logic [ROW_W-1:0] end_row
);
    logic            sclk_rise, sclk_fall, ss_fall, ss_act, mosi_s;
    logic            cmd_valid;
    frame_t          frame;
    logic [TX_W-1:0] status;

    spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ss_fall(ss_fall),
        .ss_act(ss_act), .mosi_s(mosi_s)
    );

    spi_frame_rx u_rx (
        .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .mosi_s(mosi_s),
        .ss_act(ss_act), .cmd_valid(cmd_valid), .frame(frame)
    );

    spi_cmd_ctrl #(.CFG_DEFAULT(CFG_DEFAULT)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .frame(frame),
        .row_addr(row_addr), .mem_full(mem_full), .eng_ack(eng_ack),
        .eng_done(eng_done), .cmd_stb(cmd_stb), .cfg_word(cfg_word),
        .start_row(start_row), .end_row(end_row), .status(status)
    );

    spi_tx u_tx (
        .clk(clk), .rst(rst), .ss_fall(ss_fall), .ss_act(ss_act),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .status(status),
        .miso(miso)
    );

endmodule

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic        clk = 1'b0, rst = 1'b1;
    logic        sclk = 1'b1, ss_n = 1'b1, mosi = 1'b0;
    logic [10:0] row = 11'h2A5;
    logic        full = 1'b0, ack = 1'b0, done = 1'b0;
    logic        miso;
    logic [10:0] cmd_stb, start_row, end_row;
    logic [11:0] cfg_word;

    spi_cmd_slave dut (
        .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso),
        .row_addr(row), .mem_full(full), .eng_ack(ack), .eng_done(done),
        .cmd_stb(cmd_stb), .cfg_word(cfg_word), .start_row(start_row), .end_row(end_row)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, stb_total = 0;
    logic [10:0] stb_last = '0;
    bit finished = 0;
    logic [7:0] txb [7];
    logic [7:0] rxb [7];
    logic [15:0] s0;
    logic [7:0]  s1;

    always @(posedge clk) if (cmd_stb != 0) begin stb_total++; stb_last = cmd_stb; end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk0(logic [10:0] r, logic i, logic e, logic p, logic f, logic x);
        return {r, i, e, p, f, x};
    endfunction

    function automatic logic [7:0] mk1(logic rec, logic ply, logic rdy);
        return {4'b0, rec, ply, 1'b0, rdy};
    endfunction

    task automatic clr_tx();
        for (int i = 0; i < 7; i++) begin txb[i] = 8'h00; rxb[i] = 8'h00; end
    endtask

    task automatic frame(input int nbits, input bit collide);
        ss_n = 1'b0;
        #(5*CLK_PERIOD);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = txb[i/8][i%8];
            #HALF;
            rxb[i/8][i%8] = miso;
            sclk = 1'b1;
            if (collide && i == nbits - 1) begin
                #(3*CLK_PERIOD); done = 1'b1;
                #CLK_PERIOD;     done = 1'b0;
                #(HALF - 4*CLK_PERIOD);
            end else begin
                #HALF;
            end
        end
        mosi = 1'b0;
        ss_n = 1'b1;
        #(10*CLK_PERIOD);
    endtask

    task automatic cmd2(input logic [7:0] op, input bit collide);
        clr_tx(); txb[0] = op; frame(16, collide);
    endtask

    task automatic rd_status();
        clr_tx(); txb[0] = 8'h05; frame(24, 0);
        s0 = {rxb[1], rxb[0]};
        s1 = rxb[2];
    endtask

    task automatic ranged(input logic [7:0] op, input logic [10:0] sa, input logic [10:0] ea, input int nbits);
        clr_tx();
        txb[0] = op; txb[1] = 8'hFF;
        txb[2] = sa[7:0]; txb[3] = {5'b10100, sa[10:8]};
        txb[4] = ea[7:0]; txb[5] = {5'b01011, ea[10:8]};
        txb[6] = 8'h41;
        frame(nbits, 0);
    endtask

    task automatic pulse(input bit is_ack);
        @(negedge clk);
        if (is_ack) ack = 1'b1; else done = 1'b1;
        @(negedge clk);
        ack = 1'b0; done = 1'b0;
        #(4*CLK_PERIOD);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(150000*CLK_PERIOD);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int t;
        logic [11:0] v;
        logic [7:0] bad_ops [7];
        bad_ops = '{8'h01, 8'h40, 8'h41, 8'h45, 8'h80, 8'h81, 8'h33};

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #(2*CLK_PERIOD);

        // reset state
        chk("R8 reset strobes", cmd_stb, 0);
        chk("R6 reset config", cfg_word, 0);
        chk("R7 reset start", start_row, 0);
        chk("R2 idle miso", miso, 0);
        rd_status();
        chk("R3 reset primary", s0, mk0(11'h2A5, 0, 0, 0, 0, 0));
        chk("R4 reset secondary", s1, mk1(0, 0, 1));

        // R3 sweep of row and full captured at select fall
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 13; k++) begin
                row  = (k == 11) ? 11'h000 : (k == 12) ? 11'h7FF : (11'h1 << k);
                full = f[0];
                rd_status();
                chk("R3 row/full echo", s0, mk0(row, 0, 0, 0, f[0], 0));
                chk("R1 R4 read-status secondary", s1, mk1(0, 0, 1));
            end
        end
        row = 11'h2A5; full = 1'b0;

        // R8 power-down acceptance
        cmd2(8'h40, 0);
        rd_status();
        chk("R8 play rejected in power-down", s0, mk0(row, 0, 0, 0, 0, 1));
        cmd2(8'h01, 0);
        chk("R8 power-up strobe", stb_last, 11'h001);
        rd_status();
        chk("R8 powered-up flag", s0, mk0(row, 0, 0, 1, 0, 0));

        // R6 config sweep
        for (int k = 0; k < 16; k++) begin
            v = (k < 12) ? (12'h1 << k) : (k == 12) ? 12'h000 : (k == 13) ? 12'hFFF : (k == 14) ? 12'hA5C : 12'h3C1;
            clr_tx();
            txb[0] = 8'h45; txb[1] = v[7:0]; txb[2] = {~v[11:8], v[11:8]};
            frame(24, 0);
            chk("R6 config word", cfg_word, v);
        end

        // R5 extra bytes ignored
        t = stb_total;
        clr_tx();
        txb[0] = 8'h45; txb[1] = 8'h34; txb[2] = 8'h02; txb[3] = 8'h40; txb[4] = 8'h41;
        frame(40, 0);
        chk("R5 single strobe", stb_total - t, 1);
        chk("R5 strobe is config", stb_last, 11'h100);
        chk("R5 config value", cfg_word, 12'h234);
        rd_status();
        chk("R5 trailing opcode ignored", s1, mk1(0, 0, 1));

        cmd2(8'h33, 0);
        rd_status();
        chk("R5 unknown opcode error", s0, mk0(row, 0, 0, 1, 0, 1));
        rd_status();
        chk("R8 accepted clears error", s0, mk0(row, 0, 0, 1, 0, 0));

        // record mode, ready handshake
        cmd2(8'h41, 0);
        chk("R8 record strobe", stb_last, 11'h080);
        rd_status();
        chk("R10 ready low after start", s1, mk1(1, 0, 0));
        pulse(1);
        rd_status();
        chk("R10 ready after begun", s1, mk1(1, 0, 1));

        // R8 disallowed sweep while recording
        for (int k = 0; k < 7; k++) begin
            t = stb_total;
            clr_tx();
            txb[0] = bad_ops[k]; txb[1] = 8'hFF; txb[2] = 8'hFF; txb[3] = 8'h07;
            frame((bad_ops[k] == 8'h45) ? 24 : (bad_ops[k][7]) ? 56 : 16, 0);
            chk("R8 no strobe when rejected", stb_total - t, 0);
            chk("R8 config untouched", cfg_word, 12'h234);
            chk("R8 start untouched", start_row, 0);
            rd_status();
            chk("R8 error set in record", s0, mk0(row, 0, 0, 1, 0, 1));
            chk("R8 still recording", s1, mk1(1, 0, 1));
        end
        cmd2(8'h04, 0);
        chk("R8 clear-int accepted in record", stb_last, 11'h008);

        // R11 done and stop
        pulse(0);
        rd_status();
        chk("R11 done sets flags", s0, mk0(row, 1, 1, 1, 0, 0));
        chk("R11 done returns idle", s1, mk1(0, 0, 1));
        cmd2(8'h02, 0);
        rd_status();
        chk("R11 stop clears flags", s0, mk0(row, 0, 0, 1, 0, 0));

        // R7 R9 ranged play
        ranged(8'h80, 11'h123, 11'h7FE, 56);
        chk("R7 start row", start_row, 11'h123);
        chk("R7 end row", end_row, 11'h7FE);
        rd_status();
        chk("R10 ranged play ready low", s1, mk1(0, 1, 0));
        ranged(8'h80, 11'h5A0, 11'h005, 56);
        chk("R9 second ranged play start", start_row, 11'h5A0);
        chk("R9 second ranged play end", end_row, 11'h005);
        ranged(8'h81, 11'h333, 11'h444, 56);
        chk("R9 ranged record rejected in play", start_row, 11'h5A0);
        rd_status();
        chk("R9 error flag", s0, mk0(row, 0, 0, 1, 0, 1));
        cmd2(8'h02, 0);
        rd_status();
        chk("R11 stop from ranged play", s1, mk1(0, 0, 1));

        // R9 ranged record
        ranged(8'h81, 11'h010, 11'h3FF, 56);
        chk("R7 record start", start_row, 11'h010);
        chk("R7 record end", end_row, 11'h3FF);
        ranged(8'h80, 11'h111, 11'h111, 56);
        chk("R9 ranged play rejected in record", start_row, 11'h010);
        ranged(8'h81, 11'h600, 11'h601, 56);
        chk("R9 second ranged record", end_row, 11'h601);
        rd_status();
        chk("R9 recording flags", s1, mk1(1, 0, 0));
        cmd2(8'h02, 0);

        // R12 abort
        t = stb_total;
        ranged(8'h80, 11'h111, 11'h222, 32);
        ranged(8'h80, 11'h111, 11'h222, 13);
        chk("R12 no strobe on abort", stb_total - t, 0);
        chk("R12 start kept", start_row, 11'h600);
        rd_status();
        chk("R12 next frame clean", s0, mk0(row, 0, 0, 1, 0, 0));
        chk("R12 still idle", s1, mk1(0, 0, 1));

        // R13 collisions with engine done
        cmd2(8'h41, 0); pulse(1);
        cmd2(8'h04, 1);
        rd_status();
        chk("R13 clear-int beats done", s0, mk0(row, 0, 0, 1, 0, 0));
        chk("R13 done idles", s1, mk1(0, 0, 1));
        cmd2(8'h41, 0); pulse(1);
        cmd2(8'h40, 1);
        rd_status();
        chk("R13 rejected plus done", s0, mk0(row, 1, 1, 1, 0, 1));
        chk("R13 idle after reject+done", s1, mk1(0, 0, 1));
        cmd2(8'h41, 0); pulse(1);
        cmd2(8'h02, 1);
        rd_status();
        chk("R13 stop with done", s0, mk0(row, 0, 0, 1, 0, 0));

        // reset command back to power-down
        cmd2(8'h03, 0);
        chk("R8 reset strobe", stb_last, 11'h004);
        chk("R8 reset restores config", cfg_word, 0);
        rd_status();
        chk("R8 reset to power-down", s0, mk0(row, 0, 0, 0, 0, 0));

        finish_run();
    end
endmodule